// File: doc/BRIEF.md
# Two-Channel Converter Serial Link Controller

This block is the host side of a four-wire serial link to a two-input successive-approximation converter. A request names the input to convert in the following cycle and whether the converter should stay in daisy-chain operation or return to normal operation. The block then runs one framed transfer of sixteen serial clocks. During the frame it shifts a 16-bit command out on the data output and captures the 16-bit word the converter returns on the data input.

When the frame closes, the block presents the right-aligned conversion result, the input the result was taken from, and a flag that says whether the converter reported daisy-chain operation. A framing-error flag and a one-cycle valid strobe come with them. The serial clock is divided from the system clock by a parameter. A second parameter selects 12-bit or 10-bit returned results.

Top module: `adc_link_ctrl`

## Requirements
- R1: After reset, and whenever no frame is running, `cs_n` and `sclk` are high, `busy` is low and `res_valid` is low.
- R2: An accepted request drops `cs_n` on the next clock. The frame has exactly 16 falling edges of `sclk`. Each high half and each low half of `sclk` lasts HALF_DIV system clocks. The first falling edge comes HALF_DIV clocks after `cs_n` falls. `cs_n` rises, with `sclk` high, HALF_DIV clocks after the 16th falling edge.
- R3: The command goes out MSB first on `sdo`, with command bit 15 ahead of the first falling edge. Bit 13 carries `req_chan`. Bit 12 equals `req_chan` when `req_chain` is 0 and its inverse when `req_chain` is 1. All other bits are 0. `sdo` changes only while `sclk` is high.
- R4: The returned word is taken from `sdi` MSB first, one bit in the last system clock of each `sclk` high half. Returned bit 15 must be valid once `cs_n` is low.
- R5: With RES_BITS = 12, `res_data` equals returned bits 11..0, and `res_chan` equals returned bit 13.
- R6: `res_chain` is 1 when returned bit 13 differs from returned bit 12, and 0 when they are equal.
- R7: With RES_BITS = 10, `res_data` equals returned bits 11..2 in its low ten bits, with its top two bits 0.
- R8: `res_err` is 1 when returned bit 15 or bit 14 is 1. With RES_BITS = 10 it is also 1 when returned bit 1 or bit 0 is 1.
- R9: `busy` is high from the clock after an accepted request until the clock of `res_valid`. A request while `busy` is high is ignored: it starts no frame and changes neither the command nor the result.
- R10: `res_valid` is a one-cycle pulse 32*HALF_DIV clocks after the accepting edge. The result outputs hold their values until the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Start a frame (taken when not busy) |
| req_chan | input | 1 | Input to convert in the following cycle |
| req_chain | input | 1 | 1 asks for daisy-chain operation, 0 for normal |
| busy | output | 1 | Frame in progress |
| cs_n | output | 1 | Frame select to the converter, active low |
| sclk | output | 1 | Serial clock, idle high |
| sdo | output | 1 | Command data to the converter |
| sdi | input | 1 | Returned data from the converter |
| res_valid | output | 1 | One-cycle strobe for a new result |
| res_data | output | 12 | Right-aligned conversion result |
| res_chan | output | 1 | Input the result belongs to |
| res_chain | output | 1 | Converter reported daisy-chain operation |
| res_err | output | 1 | Framing error in the returned word |

## Verification
The bench counts system clocks from the edge that takes the request. It expects `busy` one clock later and the result strobe exactly 32*HALF_DIV clocks later, and it samples every output on the falling system clock edge so that each value is read a half cycle after it settles. Frame shape is measured from the converter model's viewpoint. The model records the times of the `cs_n` edges and of each falling `sclk` edge, and checks the lead and trail gaps against HALF_DIV periods and the edge count against 16. The command is collected on those same falling edges. A 12-bit and a 10-bit instance run side by side on the same returned words, so that stripping and trailing-bit errors are compared vector by vector.

// File: rtl/adc_link_pkg.sv
`timescale 1ns/1ps
package adc_link_pkg;

    localparam int FRAME_BITS = 16;
    localparam int CHAN_POS   = 13;
    localparam int MODE_POS   = 12;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } phase_e;

    typedef struct packed {
        logic [11:0] data;
        logic        chan;
        logic        chain;
        logic        err;
    } result_t;

    // Command word: next-input bit, and a mode bit that differs from it to keep chain operation.
    function automatic logic [FRAME_BITS-1:0] build_cmd(input logic chan, input logic chain);
        logic [FRAME_BITS-1:0] w;
        w           = '0;
        w[CHAN_POS] = chan;
        w[MODE_POS] = chan ^ chain;
        return w;
    endfunction

endpackage

// File: rtl/adc_link_timer.sv
`timescale 1ns/1ps
module adc_link_timer #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic half_end
);
    localparam int            CW   = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        half_end = run && (cnt_q == LAST);
        if (!run || half_end) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/adc_link_shift.sv
`timescale 1ns/1ps
module adc_link_shift
    import adc_link_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic                  load_chan,
    input  logic                  load_chain,
    input  logic                  sample,
    input  logic                  advance,
    input  logic                  sdi,
    output logic                  sdo,
    output logic [FRAME_BITS-1:0] rx_word
);
    typedef struct packed {
        logic [FRAME_BITS-1:0] tx;
        logic [FRAME_BITS-1:0] rx;
    } shift_t;

    shift_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load) begin
            sh_d.tx = build_cmd(load_chan, load_chain);
        end else if (advance) begin
            sh_d.tx = {sh_q.tx[FRAME_BITS-2:0], 1'b0};
        end
        if (sample) begin
            sh_d.rx = {sh_q.rx[FRAME_BITS-2:0], sdi};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign sdo     = sh_q.tx[FRAME_BITS-1];
    assign rx_word = sh_q.rx;
endmodule

// File: rtl/adc_link_decode.sv
`timescale 1ns/1ps
module adc_link_decode
    import adc_link_pkg::*;
#(
    parameter int RES_BITS = 12
) (
    input  logic [FRAME_BITS-1:0] word,
    output result_t               res
);
    logic lead_bad;

    assign lead_bad = |word[FRAME_BITS-1:FRAME_BITS-2];

    generate
        if (RES_BITS == 10) begin : g_ten
            always_comb begin
                res.data  = {2'b00, word[11:2]};
                res.chan  = word[CHAN_POS];
                res.chain = word[CHAN_POS] ^ word[MODE_POS];
                res.err   = lead_bad | (|word[1:0]);
            end
        end else begin : g_twelve
            always_comb begin
                res.data  = word[11:0];
                res.chan  = word[CHAN_POS];
                res.chain = word[CHAN_POS] ^ word[MODE_POS];
                res.err   = lead_bad;
            end
        end
    endgenerate
endmodule

// File: rtl/adc_link_ctrl.sv
`timescale 1ns/1ps
module adc_link_ctrl
    import adc_link_pkg::*;
#(
    parameter int HALF_DIV = 4,
    parameter int RES_BITS = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_chan,
    input  logic        req_chain,
    output logic        busy,
    output logic        cs_n,
    output logic        sclk,
    output logic        sdo,
    input  logic        sdi,
    output logic        res_valid,
    output logic [11:0] res_data,
    output logic        res_chan,
    output logic        res_chain,
    output logic        res_err
);
    localparam int            BW       = $clog2(FRAME_BITS);
    localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);

    typedef struct packed {
        phase_e        phase;
        logic [BW-1:0] bit_cnt;
        result_t       res;
        logic          res_valid;
    } ctrl_t;

    ctrl_t                 st_d, st_q;
    logic                  half_end;
    logic                  accept;
    logic                  sample;
    logic                  advance;
    logic [FRAME_BITS-1:0] rx_word;
    result_t               dec;

    assign accept  = req_valid && (st_q.phase == PH_IDLE);
    assign sample  = (st_q.phase == PH_HIGH) && half_end;
    assign advance = (st_q.phase == PH_LOW) && half_end;

    adc_link_timer #(.HALF_DIV(HALF_DIV)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (st_q.phase != PH_IDLE),
        .half_end (half_end)
    );

    adc_link_shift u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .load_chan  (req_chan),
        .load_chain (req_chain),
        .sample     (sample),
        .advance    (advance),
        .sdi        (sdi),
        .sdo        (sdo),
        .rx_word    (rx_word)
    );

    adc_link_decode #(.RES_BITS(RES_BITS)) u_decode (
        .word (rx_word),
        .res  (dec)
    );

    always_comb begin
        st_d           = st_q;
        st_d.res_valid = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (accept) begin
                    st_d.phase   = PH_HIGH;
                    st_d.bit_cnt = '0;
                end
            end
            PH_HIGH: begin
                if (half_end) begin
                    st_d.phase = PH_LOW;
                end
            end
            PH_LOW: begin
                if (half_end) begin
                    if (st_q.bit_cnt == LAST_BIT) begin
                        st_d.phase     = PH_IDLE;
                        st_d.res       = dec;
                        st_d.res_valid = 1'b1;
                    end else begin
                        st_d.phase   = PH_HIGH;
                        st_d.bit_cnt = st_q.bit_cnt + 1'b1;
                    end
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, bit_cnt: '0, res: '0, res_valid: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy      = (st_q.phase != PH_IDLE);
    assign cs_n      = (st_q.phase == PH_IDLE);
    assign sclk      = (st_q.phase != PH_LOW);
    assign res_valid = st_q.res_valid;
    assign res_data  = st_q.res.data;
    assign res_chan  = st_q.res.chan;
    assign res_chain = st_q.res.chain;
    assign res_err   = st_q.res.err;
endmodule

// File: rtl/adc_link_chk.sv
`timescale 1ns/1ps
module adc_link_chk #(
    parameter int RES_BITS = 12
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        busy,
    input logic        cs_n,
    input logic        sclk,
    input logic        sdo,
    input logic        res_valid,
    input logic [11:0] res_data
);
    logic       sclk_prev;
    logic [4:0] fall_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev <= 1'b1;
            fall_cnt  <= '0;
        end else begin
            sclk_prev <= sclk;
            if (cs_n) begin
                fall_cnt <= '0;
            end else if (sclk_prev && !sclk) begin
                fall_cnt <= fall_cnt + 1'b1;
            end
        end
    end

    AST_SCLK_ONLY_FRAMED: assert property (@(posedge clk) disable iff (!rst_n) !sclk |-> !cs_n); // R2
    AST_SIXTEEN_FALLS: assert property (@(posedge clk) disable iff (!rst_n) $rose(cs_n) |-> fall_cnt == 5'd16); // R2
    AST_VALID_AT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n) res_valid |-> $rose(cs_n)); // R2
    AST_DIN_HELD_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n) $fell(sclk) |-> $stable(sdo)); // R3
    AST_TEN_BIT_TOP: assert property (@(posedge clk) disable iff (!rst_n) res_valid |-> (RES_BITS == 12 || res_data[11:10] == 2'b00)); // R7
    AST_START_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(req_valid)); // R9
    AST_VALID_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) res_valid |-> !busy && $past(busy)); // R9
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n) res_valid |=> !res_valid); // R10
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n) !res_valid |-> $stable(res_data)); // R10
endmodule

bind adc_link_ctrl adc_link_chk #(.RES_BITS(RES_BITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .sdo       (sdo),
    .res_valid (res_valid),
    .res_data  (res_data)
);

// File: tb/tb_adc_link_ctrl.sv
`timescale 1ns/1ps
module tb_adc_link_ctrl;
    localparam int H = 4;

    typedef struct packed {
        logic        chan;
        logic        chain;
        logic [15:0] word;
        logic [15:0] cmd;
        logic [11:0] data;
        logic        rchan;
        logic        rchain;
        logic        err;
        logic [11:0] data10;
        logic        err10;
    } vec_t;

    localparam vec_t VEC [0:7] = '{
        '{1'b0, 1'b0, 16'h0ABC, 16'h0000, 12'hABC, 1'b0, 1'b0, 1'b0, 12'h2AF, 1'b0},
        '{1'b1, 1'b0, 16'h3FFF, 16'h3000, 12'hFFF, 1'b1, 1'b0, 1'b0, 12'h3FF, 1'b1},
        '{1'b0, 1'b1, 16'h1123, 16'h1000, 12'h123, 1'b0, 1'b1, 1'b0, 12'h048, 1'b1},
        '{1'b1, 1'b1, 16'h2800, 16'h2000, 12'h800, 1'b1, 1'b1, 1'b0, 12'h200, 1'b0},
        '{1'b0, 1'b0, 16'h8001, 16'h0000, 12'h001, 1'b0, 1'b0, 1'b1, 12'h000, 1'b1},
        '{1'b1, 1'b0, 16'h4FFE, 16'h3000, 12'hFFE, 1'b0, 1'b0, 1'b1, 12'h3FF, 1'b1},
        '{1'b0, 1'b0, 16'h0000, 16'h0000, 12'h000, 1'b0, 1'b0, 1'b0, 12'h000, 1'b0},
        '{1'b1, 1'b1, 16'h2C05, 16'h2000, 12'hC05, 1'b1, 1'b1, 1'b0, 12'h301, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_chan = 1'b0, req_chain = 1'b0;
    logic busy, cs_n, sclk, sdo, dout = 1'b0;
    logic res_valid, res_chan, res_chain, res_err;
    logic [11:0] res_data;
    logic busy10, cs10, sclk10, sdo10, valid10, chan10, chain10, err10;
    logic [11:0] data10;

    int nchecks = 0, nfail = 0, nvalid = 0, falls = 0;
    logic [15:0] resp_word = '0, rsh = '0, din_cap = '0;
    time t_csfall = 0, t_first = 0, t_last = 0, t_csrise = 0;

    always #4 clk = ~clk;

    adc_link_ctrl #(.HALF_DIV(H), .RES_BITS(12)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chan(req_chan),
        .req_chain(req_chain), .busy(busy), .cs_n(cs_n), .sclk(sclk), .sdo(sdo),
        .sdi(dout), .res_valid(res_valid), .res_data(res_data), .res_chan(res_chan),
        .res_chain(res_chain), .res_err(res_err));

    adc_link_ctrl #(.HALF_DIV(H), .RES_BITS(10)) dut10 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chan(req_chan),
        .req_chain(req_chain), .busy(busy10), .cs_n(cs10), .sclk(sclk10), .sdo(sdo10),
        .sdi(dout), .res_valid(valid10), .res_data(data10), .res_chan(chan10),
        .res_chain(chain10), .res_err(err10));

    // Converter model: first bit on select fall, next bit on each falling serial clock.
    always @(negedge cs_n) begin
        t_csfall = $time;
        falls    = 0;
        din_cap  = '0;
        rsh      = resp_word;
        dout     = rsh[15];
    end

    always @(negedge sclk) begin
        if (falls == 0) t_first = $time;
        t_last  = $time;
        falls   = falls + 1;
        din_cap = {din_cap[14:0], sdo};
        rsh     = {rsh[14:0], 1'b0};
        dout    = rsh[15];
    end

    always @(posedge cs_n) t_csrise = $time;

    always @(posedge clk) if (res_valid) nvalid = nvalid + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchecks = nchecks + 1;
        if (act !== exp) begin
            nfail = nfail + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_frame(input logic chan, input logic chain, input logic [15:0] word,
                             input bit poke, output int cycles, output logic busy_early);
        @(negedge clk);
        resp_word = word;
        req_chan  = chan;
        req_chain = chain;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid  = 1'b0;
        cycles     = 1;
        busy_early = busy;
        while (!res_valid && cycles < 2000) begin
            @(negedge clk);
            cycles = cycles + 1;
            if (poke && cycles == 10) begin
                req_valid = 1'b1;
                req_chan  = ~chan;
                req_chain = ~chain;
            end
            if (poke && cycles == 11) req_valid = 1'b0;
        end
    endtask

    initial begin
        #1600000;
        nfail = nfail + 1;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
        $finish;
    end

    initial begin
        int cyc;
        logic be;
        logic [11:0] held;
        int nv;
        int fb;
        repeat (3) @(negedge clk);
        // R1: idle state after reset
        chk("R1 cs_n", {31'd0, cs_n}, 32'd1);
        chk("R1 sclk", {31'd0, sclk}, 32'd1);
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 res_valid", {31'd0, res_valid}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 cs_n out of reset", {31'd0, cs_n}, 32'd1);

        for (int i = 0; i < 8; i++) begin
            run_frame(VEC[i].chan, VEC[i].chain, VEC[i].word, 1'b0, cyc, be);
            chk("R10 strobe latency", cyc, 32'(32 * H + 1));
            chk("R9 busy after accept", {31'd0, be}, 32'd1);
            chk("R9 busy low at strobe", {31'd0, busy}, 32'd0);
            chk("R2 falling edges", falls, 32'd16);
            chk("R2 lead gap", 32'(t_first - t_csfall), 32'(8 * H));
            chk("R2 trail gap", 32'(t_csrise - t_last), 32'(8 * H));
            chk("R3 command word", {16'd0, din_cap}, {16'd0, VEC[i].cmd});
            chk("R4 R5 data", {20'd0, res_data}, {20'd0, VEC[i].data});
            chk("R5 channel", {31'd0, res_chan}, {31'd0, VEC[i].rchan});
            chk("R6 chain flag", {31'd0, res_chain}, {31'd0, VEC[i].rchain});
            chk("R8 error", {31'd0, res_err}, {31'd0, VEC[i].err});
            chk("R7 ten-bit data", {20'd0, data10}, {20'd0, VEC[i].data10});
            chk("R8 ten-bit error", {31'd0, err10}, {31'd0, VEC[i].err10});
            chk("R6 ten-bit chain flag", {31'd0, chain10}, {31'd0, VEC[i].rchain});
            chk("R10 ten-bit strobe", {31'd0, valid10}, 32'd1);
        end

        // R10: single pulse, result holds afterwards
        @(negedge clk);
        chk("R10 pulse one cycle", {31'd0, res_valid}, 32'd0);
        held = res_data;
        repeat (20) @(negedge clk);
        chk("R10 result held", {20'd0, res_data}, {20'd0, held});

        // R9: request during a frame is ignored
        nv = nvalid;
        run_frame(1'b0, 1'b0, 16'h0555, 1'b1, cyc, be);
        chk("R9 command unchanged by poke", {16'd0, din_cap}, 32'h0000);
        chk("R9 result unchanged by poke", {20'd0, res_data}, 32'h555);
        chk("R9 poke latency", cyc, 32'(32 * H + 1));
        fb = falls;
        repeat (3 * 32 * H) @(negedge clk);
        chk("R9 no second frame", {31'd0, busy}, 32'd0);
        chk("R9 single strobe", nvalid - nv, 32'd1);
        chk("R9 no extra edges", falls, fb);
        chk("R1 idle lines after frame", {30'd0, cs_n, sclk}, 32'd3);

        // R3 R6: back-to-back chain then normal request
        run_frame(1'b1, 1'b1, 16'h3001, 1'b0, cyc, be);
        chk("R3 chain command", {16'd0, din_cap}, 32'h2000);
        chk("R6 equal bits give normal", {31'd0, res_chain}, 32'd0);
        run_frame(1'b0, 1'b1, 16'h1001, 1'b0, cyc, be);
        chk("R3 chain command input0", {16'd0, din_cap}, 32'h1000);
        chk("R6 unequal bits give chain", {31'd0, res_chain}, 32'd1);

        $display("  TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
        $finish;
    end
endmodule